// File: doc/BRIEF.md
# I2C Target Register Port

This block is a target (slave) on a two-wire I2C-compatible bus that gives a bus master read and write access to a small bank of byte registers. Both bus lines enter through a two-flop synchronizer and a glitch filter running on the system clock. The controller watches the filtered lines for start and stop conditions, compares the first byte with its own 7-bit device address, and then handles a subaddress followed by data bytes. The subaddress advances by one after each byte.

One bit of the device address comes from a strap input, so two copies can sit on one bus. The block never drives SDA high. Its only output is a low-enable for an external open-drain pad. Register data can only be seen through bus reads.

The end of the register map follows fixed rules. A subaddress above the top register is refused. A burst read that reaches the top register keeps returning that register. A burst write that would go past the top register is refused, and that byte is not stored.

Top module: `i2c_regport`

## Requirements
- R1: After reset, every register reads as 0x00 and the SDA low-enable is deasserted.
- R2: The first byte after a start holds the device address in bits 7..1 and the direction in bit 0 (1 = read, 0 = write). The device address is 0b011010s, where s is the strap input. On a match the block pulls SDA low during the ninth SCL pulse. On a mismatch it does not acknowledge, and it ignores the bus until the next start.
- R3: A start is SDA falling while SCL is high. A stop is SDA rising while SCL is high. SDA changes while SCL is low are data, not conditions, so clocking a byte without a preceding start gets no acknowledge.
- R4: In a write transfer, the byte after the address is the subaddress. A subaddress not above TOP_SUB (default 0x0F) is acknowledged. A larger one gets a no-acknowledge, the block returns to idle, and later bytes of that transfer are not stored.
- R5: Each data byte of a write transfer is stored at the current subaddress and acknowledged, and the subaddress then increments by one.
- R6: A read is done as a write of the subaddress, then a repeated start, then the address byte with bit 0 = 1. The block then sends data MSB first, starting at the current subaddress and advancing after each byte that the master acknowledges.
- R7: In a burst read, once the top register has been sent, each further byte repeats the top register until the master gives a no-acknowledge.
- R8: In a burst write, a byte that arrives after the top register was written is not stored. It gets a no-acknowledge and the block returns to idle. The map does not wrap to subaddress 0.
- R9: A stop in the middle of a byte aborts the transfer without storing anything. A start during a write transfer acts as a repeated start that begins a new transfer.
- R10: The SDA low-enable changes only while SCL is low. It is stable for the whole of each SCL high phase.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock, much faster than SCL |
| rst_n | input | 1 | Active-low asynchronous reset |
| scl_i | input | 1 | Bus clock line level |
| sda_i | input | 1 | Bus data line level (the wired-AND result) |
| addr_sel_i | input | 1 | Strap that sets bit 0 of the device address |
| sda_oe_o | output | 1 | Pull SDA low when 1 |

## Verification
A bus line change reaches the controller after two synchronizer flops plus FILT_CYC filter cycles. The low-enable then moves one cycle after the filtered SCL falling edge, so a new output bit is due about six system cycles after SCL falls. The bench holds each SCL phase for 20 cycles and samples SDA in the middle of the SCL high phase, well after that latency and well before the next edge. It also samples SDA a second time just before SCL falls, which confirms the acknowledge level did not move while SCL was high.

// File: rtl/i2c_rp_pkg.sv
package i2c_rp_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_ADDR,
        ST_SUB,
        ST_WDAT,
        ST_AWAIT,
        ST_AHOLD,
        ST_RDAT,
        ST_RACK
    } rp_state_e;

    typedef struct packed {
        rp_state_e  st;
        rp_state_e  nxt;
        logic [2:0] cnt;
        logic [7:0] sh;
        logic [7:0] ptr;
        logic       past;
        logic       ack;
        logic       oe;
        logic       scl_p;
        logic       sda_p;
    } rp_ctl_t;

endpackage

// File: rtl/i2c_rp_filt.sv
module i2c_rp_filt #(
    parameter int FILT_CYC = 3
) (
    input  logic clk,
    input  logic rst_n,
    input  logic raw_i,
    output logic clean_o
);
    localparam int CW = $clog2(FILT_CYC + 1);

    typedef struct packed {
        logic [1:0]    sync;
        logic [CW-1:0] cnt;
        logic          out;
    } filt_t;

    filt_t d, q;

    always_comb begin
        d      = q;
        d.sync = {q.sync[0], raw_i};
        if (q.sync[1] == q.out) begin
            d.cnt = '0;
        end else if (q.cnt == CW'(FILT_CYC - 1)) begin
            d.out = q.sync[1];
            d.cnt = '0;
        end else begin
            d.cnt = q.cnt + 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q.sync <= 2'b11;
            q.cnt  <= '0;
            q.out  <= 1'b1;
        end else begin
            q <= d;
        end
    end

    assign clean_o = q.out;
endmodule

// File: rtl/i2c_rp_bank.sv
module i2c_rp_bank #(
    parameter int DEPTH = 16
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       we_i,
    input  logic [7:0] waddr_i,
    input  logic [7:0] wdata_i,
    input  logic [7:0] raddr_i,
    output logic [7:0] rdata_o
);
    logic [7:0] mem_q [DEPTH];
    logic [7:0] mem_d [DEPTH];

    always_comb begin
        rdata_o = 8'h00;
        for (int i = 0; i < DEPTH; i++) begin
            mem_d[i] = mem_q[i];
            if (we_i && waddr_i == 8'(i)) mem_d[i] = wdata_i;
            if (raddr_i == 8'(i)) rdata_o = mem_q[i];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < DEPTH; i++) mem_q[i] <= 8'h00;
        end else begin
            for (int i = 0; i < DEPTH; i++) mem_q[i] <= mem_d[i];
        end
    end
endmodule

// File: rtl/i2c_regport.sv
module i2c_regport
    import i2c_rp_pkg::*;
#(
    parameter logic [7:0] TOP_SUB  = 8'h0F,
    parameter logic [6:0] DEV_BASE = 7'b0110100,
    parameter int         FILT_CYC = 3
) (
    input  logic clk,
    input  logic rst_n,
    input  logic scl_i,
    input  logic sda_i,
    input  logic addr_sel_i,
    output logic sda_oe_o
);
    localparam int DEPTH = int'(TOP_SUB) + 1;

    logic [1:0] raw_lines;
    logic [1:0] f_lines;
    logic       f_scl, f_sda;

    assign raw_lines = {sda_i, scl_i};

    for (genvar g = 0; g < 2; g++) begin : g_filt
        i2c_rp_filt #(.FILT_CYC(FILT_CYC)) u_filt (
            .clk    (clk),
            .rst_n  (rst_n),
            .raw_i  (raw_lines[g]),
            .clean_o(f_lines[g])
        );
    end

    assign f_scl = f_lines[0];
    assign f_sda = f_lines[1];

    rp_ctl_t    d, q;
    logic       scl_rise, scl_fall, start_det, stop_det;
    logic [7:0] byte_in, rdata, wdata;
    logic [6:0] dev_addr;
    logic       we;

    assign dev_addr  = {DEV_BASE[6:1], addr_sel_i};
    assign scl_rise  = f_scl & ~q.scl_p;
    assign scl_fall  = ~f_scl & q.scl_p;
    assign start_det = f_scl & q.scl_p & q.sda_p & ~f_sda;
    assign stop_det  = f_scl & q.scl_p & ~q.sda_p & f_sda;
    assign byte_in   = {q.sh[6:0], f_sda};
    assign wdata     = byte_in;

    i2c_rp_bank #(.DEPTH(DEPTH)) u_bank (
        .clk    (clk),
        .rst_n  (rst_n),
        .we_i   (we),
        .waddr_i(q.ptr),
        .wdata_i(wdata),
        .raddr_i(q.ptr),
        .rdata_o(rdata)
    );

    always_comb begin
        d       = q;
        we      = 1'b0;
        d.scl_p = f_scl;
        d.sda_p = f_sda;
        if (stop_det) begin
            d.st = ST_IDLE;
            d.oe = 1'b0;
        end else if (start_det) begin
            d.st  = ST_ADDR;
            d.cnt = '0;
            d.oe  = 1'b0;
        end else begin
            unique case (q.st)
                ST_ADDR, ST_SUB, ST_WDAT: begin
                    if (scl_rise) begin
                        d.sh  = byte_in;
                        d.cnt = q.cnt + 1'b1;
                        if (q.cnt == 3'd7) begin
                            d.st  = ST_AWAIT;
                            d.ack = 1'b0;
                            if (q.st == ST_ADDR) begin
                                if (byte_in[7:1] == dev_addr) begin
                                    d.ack = 1'b1;
                                    d.nxt = byte_in[0] ? ST_RDAT : ST_SUB;
                                end
                            end else if (q.st == ST_SUB) begin
                                if (byte_in <= TOP_SUB) begin
                                    d.ack  = 1'b1;
                                    d.ptr  = byte_in;
                                    d.past = 1'b0;
                                    d.nxt  = ST_WDAT;
                                end
                            end else if (!q.past) begin
                                we    = 1'b1;
                                d.ack = 1'b1;
                                d.nxt = ST_WDAT;
                                if (q.ptr == TOP_SUB) d.past = 1'b1;
                                else                  d.ptr  = q.ptr + 1'b1;
                            end
                        end
                    end
                end
                ST_AWAIT: begin
                    if (scl_fall) begin
                        if (q.ack) begin
                            d.oe = 1'b1;
                            d.st = ST_AHOLD;
                        end else begin
                            d.st = ST_IDLE;
                        end
                    end
                end
                ST_AHOLD: begin
                    if (scl_fall) begin
                        d.cnt = '0;
                        d.st  = q.nxt;
                        if (q.nxt == ST_RDAT) begin
                            d.sh = rdata;
                            d.oe = ~rdata[7];
                        end else begin
                            d.oe = 1'b0;
                        end
                    end
                end
                ST_RDAT: begin
                    if (scl_fall) begin
                        if (q.cnt == 3'd7) begin
                            d.oe  = 1'b0;
                            d.ack = 1'b0;
                            d.st  = ST_RACK;
                        end else begin
                            d.sh  = {q.sh[6:0], 1'b0};
                            d.oe  = ~q.sh[6];
                            d.cnt = q.cnt + 1'b1;
                        end
                    end
                end
                ST_RACK: begin
                    if (scl_rise) begin
                        if (f_sda) begin
                            d.st = ST_IDLE;
                        end else begin
                            d.ack = 1'b1;
                            if (q.ptr != TOP_SUB) d.ptr = q.ptr + 1'b1;
                        end
                    end else if (scl_fall && q.ack) begin
                        d.sh  = rdata;
                        d.oe  = ~rdata[7];
                        d.cnt = '0;
                        d.st  = ST_RDAT;
                    end
                end
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q.st    <= ST_IDLE;
            q.nxt   <= ST_IDLE;
            q.cnt   <= '0;
            q.sh    <= '0;
            q.ptr   <= '0;
            q.past  <= 1'b0;
            q.ack   <= 1'b0;
            q.oe    <= 1'b0;
            q.scl_p <= 1'b1;
            q.sda_p <= 1'b1;
        end else begin
            q <= d;
        end
    end

    assign sda_oe_o = q.oe;
endmodule

// File: rtl/i2c_regport_chk.sv
module i2c_regport_chk
    import i2c_rp_pkg::*;
#(
    parameter logic [7:0] TOP_SUB = 8'h0F
) (
    input logic       clk,
    input logic       rst_n,
    input logic       scl_f,
    input logic       start_det,
    input logic       stop_det,
    input rp_state_e  st,
    input logic       oe,
    input logic [7:0] ptr,
    input logic       we
);
    AST_OE_MOVES_SCL_LOW: assert property (@(posedge clk) disable iff (!rst_n)
        (oe != $past(oe)) |-> !scl_f); // R10
    AST_IDLE_RELEASED: assert property (@(posedge clk) disable iff (!rst_n)
        (st == ST_IDLE) |-> !oe); // R2
    AST_STOP_GOES_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        stop_det |=> (st == ST_IDLE)); // R3
    AST_START_GOES_ADDR: assert property (@(posedge clk) disable iff (!rst_n)
        (start_det && !stop_det) |=> (st == ST_ADDR)); // R9
    AST_PTR_IN_MAP: assert property (@(posedge clk) disable iff (!rst_n)
        ptr <= TOP_SUB); // R7
    AST_WRITE_IN_MAP: assert property (@(posedge clk) disable iff (!rst_n)
        we |-> (ptr <= TOP_SUB) && (st == ST_WDAT)); // R8
endmodule

bind i2c_regport i2c_regport_chk #(.TOP_SUB(TOP_SUB)) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .scl_f    (f_scl),
    .start_det(start_det),
    .stop_det (stop_det),
    .st       (q.st),
    .oe       (q.oe),
    .ptr      (q.ptr),
    .we       (we)
);

// File: tb/test_i2c_regport.sv
`timescale 1ns/1ps
module test_i2c_regport;
    localparam int Q = 20;
    localparam logic [7:0] TOPR = 8'h0F;

    typedef struct packed {
        logic       sel;
        logic [7:0] sub;
        logic [7:0] dat;
    } vec_t;

    localparam vec_t VEC [0:5] = '{
        '{1'b0, 8'h00, 8'hA5},
        '{1'b1, 8'h03, 8'h3C},
        '{1'b0, 8'h0F, 8'hFF},
        '{1'b1, 8'h07, 8'h01},
        '{1'b0, 8'h0A, 8'h80},
        '{1'b1, 8'h01, 8'h5A}
    };

    logic clk = 1'b0, rst_n = 1'b0, scl = 1'b1, m_sda = 1'b1, strap = 1'b0;
    logic sda_oe;
    wire  sda_line = m_sda & ~sda_oe;
    int   n_vec = 0, n_bad = 0, stab_err = 0;
    logic last_ack;
    logic [7:0] rd_byte;
    logic [7:0] wbuf [0:7];
    logic [7:0] rbuf [0:7];
    logic       ackv [0:9];
    logic [7:0] model [0:15];
    logic       done = 1'b0;

    always #10 clk = ~clk;

    i2c_regport i_i2c_regport (
        .clk(clk), .rst_n(rst_n), .scl_i(scl), .sda_i(sda_line),
        .addr_sel_i(strap), .sda_oe_o(sda_oe)
    );

    task automatic tk(input int n);
        repeat (n) @(posedge clk);
        #2;
    endtask

    task automatic chk(input string rq, input logic [31:0] act, input logic [31:0] exp);
        n_vec++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %0h expected %0h", rq, act, exp);
        end
    endtask

    task automatic b_start();
        m_sda = 1'b1; tk(Q); scl = 1'b1; tk(Q); m_sda = 1'b0; tk(Q); scl = 1'b0; tk(Q);
    endtask

    task automatic b_stop();
        m_sda = 1'b0; tk(Q); scl = 1'b1; tk(Q); m_sda = 1'b1; tk(Q);
    endtask

    task automatic put_bit(input logic b);
        m_sda = b; tk(Q); scl = 1'b1; tk(Q); scl = 1'b0; tk(4);
    endtask

    task automatic put_byte(input logic [7:0] b);
        logic s_mid;
        for (int i = 7; i >= 0; i--) put_bit(b[i]);
        m_sda = 1'b1; tk(Q); scl = 1'b1; tk(Q/2);
        s_mid = sda_line;
        tk(Q/2 - 2);
        if (sda_line !== s_mid) stab_err++;
        tk(2); scl = 1'b0; tk(4);
        last_ack = (s_mid == 1'b0);
    endtask

    task automatic get_byte(input logic ack);
        logic [7:0] v;
        v = '0;
        for (int i = 0; i < 8; i++) begin
            m_sda = 1'b1; tk(Q); scl = 1'b1; tk(Q/2);
            v = {v[6:0], sda_line};
            tk(Q/2); scl = 1'b0; tk(4);
        end
        m_sda = ack ? 1'b0 : 1'b1; tk(Q); scl = 1'b1; tk(Q); scl = 1'b0; tk(4);
        m_sda = 1'b1;
        rd_byte = v;
    endtask

    function automatic logic [6:0] dev(input logic s);
        return {6'b011010, s};
    endfunction

    task automatic wr_txn(input logic s, input logic [7:0] sub, input int n);
        b_start();
        put_byte({dev(s), 1'b0}); ackv[0] = last_ack;
        put_byte(sub);            ackv[1] = last_ack;
        for (int i = 0; i < n; i++) begin
            put_byte(wbuf[i]); ackv[2+i] = last_ack;
        end
        b_stop();
    endtask

    task automatic rd_txn(input logic s, input logic [7:0] sub, input int n);
        b_start();
        put_byte({dev(s), 1'b0}); ackv[0] = last_ack;
        put_byte(sub);            ackv[1] = last_ack;
        b_start();
        put_byte({dev(s), 1'b1}); ackv[2] = last_ack;
        for (int i = 0; i < n; i++) begin
            get_byte(i != n - 1); rbuf[i] = rd_byte;
        end
        b_stop();
    endtask

    initial begin
        for (int i = 0; i < 16; i++) model[i] = 8'h00;
        tk(5);
        rst_n = 1'b1;
        tk(5);
        chk("R1 oe after reset", sda_oe, 1'b0);
        rd_txn(1'b0, 8'h05, 1);
        chk("R1 reset register value", rbuf[0], 8'h00);
        chk("R6 read address ack", ackv[2], 1'b1);

        // Table walk: single write, then read back through repeated start
        for (int v = 0; v < 6; v++) begin
            strap = VEC[v].sel;
            wbuf[0] = VEC[v].dat;
            wr_txn(VEC[v].sel, VEC[v].sub, 1);
            model[VEC[v].sub[3:0]] = VEC[v].dat;
            chk("R2 address ack", ackv[0], 1'b1);
            chk("R4 subaddress ack", ackv[1], 1'b1);
            chk("R5 data ack", ackv[2], 1'b1);
            rd_txn(VEC[v].sel, VEC[v].sub, 1);
            chk("R6 read back", rbuf[0], VEC[v].dat);
        end

        // R2: strap = 1, wrong address (bit0 = 0) not acked, data ignored
        strap = 1'b1;
        wbuf[0] = 8'h77;
        wr_txn(1'b0, 8'h02, 1);
        chk("R2 mismatch no ack", ackv[0], 1'b0);
        rd_txn(1'b1, 8'h02, 1);
        chk("R2 mismatch write ignored", rbuf[0], model[2]);
        strap = 1'b0;

        // R3: byte clocked without a start is not acked
        put_byte({dev(1'b0), 1'b0});
        chk("R3 no start no ack", last_ack, 1'b0);
        b_stop();

        // R5 / R6: burst write of 4 from 0x04, burst read back
        for (int i = 0; i < 4; i++) wbuf[i] = 8'h10 + 8'(i * 17);
        wr_txn(1'b0, 8'h04, 4);
        for (int i = 0; i < 4; i++) model[4+i] = wbuf[i];
        chk("R5 burst last ack", ackv[5], 1'b1);
        rd_txn(1'b0, 8'h04, 4);
        for (int i = 0; i < 4; i++) chk("R5 R6 burst data", rbuf[i], model[4+i]);

        // R4: invalid subaddress refused, following byte dropped
        wbuf[0] = 8'hEE;
        wr_txn(1'b0, TOPR + 8'h01, 1);
        chk("R4 bad subaddress nack", ackv[1], 1'b0);
        chk("R4 data after bad sub nack", ackv[2], 1'b0);
        rd_txn(1'b0, 8'h00, 1);
        chk("R4 no wrap store", rbuf[0], model[0]);

        // R8: write past the top register
        wbuf[0] = 8'h61; wbuf[1] = 8'h62; wbuf[2] = 8'h63;
        wr_txn(1'b0, 8'h0E, 3);
        model[14] = 8'h61; model[15] = 8'h62;
        chk("R8 top write ack", ackv[3], 1'b1);
        chk("R8 overflow nack", ackv[4], 1'b0);
        rd_txn(1'b0, 8'h00, 1);
        chk("R8 no wrap to 0", rbuf[0], model[0]);

        // R7: burst read saturates at the top register
        rd_txn(1'b0, 8'h0E, 4);
        chk("R7 byte0", rbuf[0], model[14]);
        chk("R7 byte1", rbuf[1], model[15]);
        chk("R7 byte2 repeat", rbuf[2], model[15]);
        chk("R7 byte3 repeat", rbuf[3], model[15]);

        // R9: stop in mid-byte aborts without storing
        b_start();
        put_byte({dev(1'b0), 1'b0});
        put_byte(8'h02);
        put_bit(1'b1); put_bit(1'b1); put_bit(1'b0); put_bit(1'b1);
        b_stop();
        rd_txn(1'b0, 8'h02, 1);
        chk("R9 aborted byte not stored", rbuf[0], model[2]);

        // R9: repeated start inside a write begins a new write
        b_start();
        put_byte({dev(1'b0), 1'b0});
        put_byte(8'h03);
        put_byte(8'hC3);
        b_start();
        put_byte({dev(1'b0), 1'b0});
        chk("R9 restart address ack", last_ack, 1'b1);
        put_byte(8'h09);
        put_byte(8'h9C);
        b_stop();
        model[3] = 8'hC3; model[9] = 8'h9C;
        rd_txn(1'b0, 8'h03, 1);
        chk("R9 first write kept", rbuf[0], model[3]);
        rd_txn(1'b0, 8'h09, 1);
        chk("R9 second write kept", rbuf[0], model[9]);

        chk("R10 ack level stable over SCL high", stab_err, 0);
        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end

    initial begin
        repeat (190000) @(posedge clk);
        if (!done) begin
            n_vec++;
            n_bad++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
            $finish;
        end
    end
endmodule